// File: doc/BRIEF.md
# Interrupt Event and Mask Controller

This block gathers interrupt requests and transfer errors from four host-port channels, a general-purpose interrupt line, two GPIO pins and a general-purpose bus. Each request is recorded in a sticky event register. A mask register qualifies the event register, and a master enable in the top mask bit gates the result. Together they drive one registered, active-high interrupt line.

Software reaches the registers over a simple 32-bit register bus. Each register has a write-to-set address and a write-to-clear address, so one bit can change without a read-modify-write. Host-port channel errors are collected in a separate sticky error report. The OR of that report appears as the host-port error event.

The block also decides, in the same cycle, how a failing bus transfer is answered. It can give a target abort, a quiet zero-data response, or a system-error indication for posted writes. The choice depends on the error mask bit of the source and on an externally supplied system-error enable.

Top module: `irq_event_ctrl`

## Requirements
- R1: After reset the event, mask and error report registers read 0, the GPIO configuration reads 0x0000000F, and irq_out is low.
- R2: Register address map:
  - Address 0 sets event bits and address 1 clears them.
  - Address 2 sets mask bits and address 3 clears them.
  - In each pair, a 1 in the write data acts on that bit, a 0 has no effect, and both addresses read the current value.
- R3: Event bits 0-3 (host-port channels), 26 (general-purpose interrupt), 27-28 (GPIO pins 0 and 1) and 29 (general-purpose bus error) are stored. All other event bits read 0 and ignore writes, except bit 30, which reads the OR of the error report.
- R4: Event bits are sticky. A hardware event in the same cycle as a software clear of that bit leaves the bit set.
- R5: Error report (address 4) bit i is set when hp_err[i] is high and is cleared by writing 1 to bit i. A hardware error in the same cycle as the clear wins.
- R6: irq_out goes high one clock after the registers hold mask bit 31 set and a nonzero AND of event and mask over bits 30:0.
- R7: While mask bit 31 is clear, irq_out is low one clock later regardless of event and mask contents.
- R8: GPIO configuration (address 5):
  - Bits [2g+1:2g] choose the event type for pin g: 00 rising, 01 falling, 10 both edges, 11 off.
  - Bit 8+g selects pin g as an interrupt input.
  - Inputs pass a synchronizer, and an event is recorded only for a selected pin with a matching edge.
- R9: With the error mask bit of a source set (bit 29 for the general-purpose bus, bit 30 for the host port), an error from that source gives no target abort and no system error. A non-posted error raises resp_zero.
- R10: With the error mask bit clear:
  - A non-posted error raises resp_abort in the same cycle.
  - A posted error raises resp_serr only when sys_err_en is high.
- R11: gp_irq sets event bit 26 and gp_err sets event bit 29.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| hp_irq | input | 4 | Host-port channel interrupt requests |
| gp_irq | input | 1 | General-purpose interrupt request |
| gpio_in | input | 2 | Asynchronous GPIO pins |
| hp_err | input | 4 | Host-port channel transfer errors |
| hp_posted | input | 1 | Current host-port error is on a posted write |
| gp_err | input | 1 | General-purpose bus transfer error |
| gp_posted | input | 1 | Current general-purpose error is on a posted write |
| sys_err_en | input | 1 | System-error output enable |
| irq_out | output | 1 | Registered interrupt output |
| resp_abort | output | 1 | Answer the transfer with a target abort |
| resp_zero | output | 1 | Answer the read with zero data |
| resp_serr | output | 1 | Signal a system error |

## Verification
A software clear and a hardware event can land on the same event bit, or on the same error report bit, in one clock. The bench holds hp_irq or hp_err high across a write of 1 to the clear address. It then reads the register back and expects the bit still set. It repeats the read after the source drops to confirm that the clear then takes effect.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int REG_W        = 32;
   localparam int EV_GPINT     = 26;
   localparam int EV_GPIO_BASE = 27;
   localparam int EV_GPERR     = 29;
   localparam int EV_HPERR     = 30;
   localparam int MASK_MASTER  = 31;
   localparam int CFG_SEL_BASE = 8;

   typedef enum logic [2:0] {
      A_EV_SET  = 3'd0,
      A_EV_CLR  = 3'd1,
      A_MK_SET  = 3'd2,
      A_MK_CLR  = 3'd3,
      A_ERR_REP = 3'd4,
      A_GPIO_CF = 3'd5
   } reg_addr_e;

   typedef enum logic [1:0] {
      GT_RISE = 2'b00,
      GT_FALL = 2'b01,
      GT_BOTH = 2'b10,
      GT_OFF  = 2'b11
   } gpio_type_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) st[0] <= '0;
               else        st[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) st[s] <= '0;
               else        st[s] <= st[s-1];
         end
      end
   endgenerate

   assign q = st[STAGES-1];
endmodule

// File: rtl/irqc_edge.sv
module irqc_edge
   import irqc_pkg::*;
#(
   parameter int STAGES = 2
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin,
   input  logic       sel,
   input  logic [1:0] gtype,
   output logic       pulse
);
   logic pin_s, pin_prev, rise, fall, hit;

   irqc_sync #(.W(1), .STAGES(STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin), .q(pin_s)
   );

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) pin_prev <= 1'b0;
      else        pin_prev <= pin_s;

   assign rise = pin_s & ~pin_prev;
   assign fall = ~pin_s & pin_prev;

   always_comb begin
      unique case (gpio_type_e'(gtype))
         GT_RISE: hit = rise;
         GT_FALL: hit = fall;
         GT_BOTH: hit = rise | fall;
         default: hit = 1'b0;
      endcase
   end

   assign pulse = sel & hit;
endmodule

// File: rtl/irqc_errresp.sv
module irqc_errresp (
   input  logic err,
   input  logic posted,
   input  logic emask,
   input  logic serr_en,
   output logic abort,
   output logic zero,
   output logic serr
);
   always_comb begin
      abort = err & ~posted & ~emask;
      zero  = err & ~posted & emask;
      serr  = err & posted & ~emask & serr_en;
   end
endmodule

// File: rtl/irq_event_ctrl.sv
module irq_event_ctrl
   import irqc_pkg::*;
#(
   parameter int NUM_HP      = 4,
   parameter int NUM_GPIO    = 2,
   parameter int SYNC_STAGES = 2
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [2:0]          reg_addr,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         reg_rdata,
   input  logic [NUM_HP-1:0]   hp_irq,
   input  logic                gp_irq,
   input  logic [NUM_GPIO-1:0] gpio_in,
   input  logic [NUM_HP-1:0]   hp_err,
   input  logic                hp_posted,
   input  logic                gp_err,
   input  logic                gp_posted,
   input  logic                sys_err_en,
   output logic                irq_out,
   output logic                resp_abort,
   output logic                resp_zero,
   output logic                resp_serr
);
   localparam int NSRC = 2;

   function automatic logic [REG_W-1:0] ev_rw_bits();
      logic [REG_W-1:0] m = '0;
      for (int i = 0; i < NUM_HP; i++)   m[i] = 1'b1;
      m[EV_GPINT] = 1'b1;
      for (int g = 0; g < NUM_GPIO; g++) m[EV_GPIO_BASE+g] = 1'b1;
      m[EV_GPERR] = 1'b1;
      return m;
   endfunction

   function automatic logic [REG_W-1:0] cfg_bits(input bit types_only);
      logic [REG_W-1:0] m = '0;
      for (int g = 0; g < NUM_GPIO; g++) begin
         m[2*g +: 2] = 2'b11;
         if (!types_only) m[CFG_SEL_BASE+g] = 1'b1;
      end
      return m;
   endfunction

   localparam logic [REG_W-1:0] EV_RW   = ev_rw_bits();
   localparam logic [REG_W-1:0] CFG_MSK = cfg_bits(1'b0);
   localparam logic [REG_W-1:0] CFG_RST = cfg_bits(1'b1);

   generate
      if (NUM_HP < 1 || NUM_HP > 4) begin : g_bad_hp
         $error("NUM_HP must be 1..4");
      end
      if (NUM_GPIO < 1 || NUM_GPIO > 2) begin : g_bad_gpio
         $error("NUM_GPIO must be 1..2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [REG_W-1:0]  ev_q, mask_q, cfg_q, hw_v, ev_view;
   logic [NUM_HP-1:0] rep_q;
   logic [NUM_GPIO-1:0] gpio_pulse;

   // GPIO edge detectors, one per pin
   generate
      for (genvar g = 0; g < NUM_GPIO; g++) begin : g_gpio
         irqc_edge #(.STAGES(SYNC_STAGES)) u_edge (
            .clk(clk), .rst_n(rst_n), .pin(gpio_in[g]),
            .sel(cfg_q[CFG_SEL_BASE+g]), .gtype(cfg_q[2*g +: 2]),
            .pulse(gpio_pulse[g])
         );
      end
   endgenerate

   always_comb begin
      hw_v = '0;
      hw_v[NUM_HP-1:0]                 = hp_irq;
      hw_v[EV_GPINT]                   = gp_irq;
      hw_v[EV_GPIO_BASE +: NUM_GPIO]   = gpio_pulse;
      hw_v[EV_GPERR]                   = gp_err;
   end

   logic wr_ev_set, wr_ev_clr, wr_mk_set, wr_mk_clr, wr_rep, wr_cfg;
   assign wr_ev_set = reg_wr && reg_addr == A_EV_SET;
   assign wr_ev_clr = reg_wr && reg_addr == A_EV_CLR;
   assign wr_mk_set = reg_wr && reg_addr == A_MK_SET;
   assign wr_mk_clr = reg_wr && reg_addr == A_MK_CLR;
   assign wr_rep    = reg_wr && reg_addr == A_ERR_REP;
   assign wr_cfg    = reg_wr && reg_addr == A_GPIO_CF;

   logic [REG_W-1:0]  ev_set_v, ev_clr_v, mk_set_v, mk_clr_v;
   logic [NUM_HP-1:0] rep_clr_v;
   assign ev_set_v  = wr_ev_set ? reg_wdata : '0;
   assign ev_clr_v  = wr_ev_clr ? reg_wdata : '0;
   assign mk_set_v  = wr_mk_set ? reg_wdata : '0;
   assign mk_clr_v  = wr_mk_clr ? reg_wdata : '0;
   assign rep_clr_v = wr_rep ? reg_wdata[NUM_HP-1:0] : '0;

   // Clear first, then set and hardware events, so an event is never lost
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ev_q   <= '0;
         mask_q <= '0;
         rep_q  <= '0;
         cfg_q  <= CFG_RST;
      end else begin
         ev_q   <= ((ev_q & ~ev_clr_v) | ev_set_v | hw_v) & EV_RW;
         mask_q <= (mask_q & ~mk_clr_v) | mk_set_v;
         rep_q  <= (rep_q & ~rep_clr_v) | hp_err;
         if (wr_cfg) cfg_q <= reg_wdata & CFG_MSK;
      end
   end

   always_comb begin
      ev_view = ev_q;
      ev_view[EV_HPERR] = |rep_q;
   end

   logic irq_d;
   assign irq_d = mask_q[MASK_MASTER] & (|(ev_view[30:0] & mask_q[30:0]));

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) irq_out <= 1'b0;
      else        irq_out <= irq_d;

   always_comb begin
      unique case (reg_addr)
         A_EV_SET, A_EV_CLR: reg_rdata = ev_view;
         A_MK_SET, A_MK_CLR: reg_rdata = mask_q;
         A_ERR_REP:          reg_rdata = {{(REG_W-NUM_HP){1'b0}}, rep_q};
         A_GPIO_CF:          reg_rdata = cfg_q;
         default:            reg_rdata = '0;
      endcase
   end

   // Error response per source: index 0 general-purpose bus, 1 host port
   logic [NSRC-1:0] src_err, src_posted, src_emask, src_abort, src_zero, src_serr;
   assign src_err    = {|hp_err, gp_err};
   assign src_posted = {hp_posted, gp_posted};
   assign src_emask  = {mask_q[EV_HPERR], mask_q[EV_GPERR]};

   generate
      for (genvar s = 0; s < NSRC; s++) begin : g_resp
         irqc_errresp u_resp (
            .err(src_err[s]), .posted(src_posted[s]), .emask(src_emask[s]),
            .serr_en(sys_err_en), .abort(src_abort[s]), .zero(src_zero[s]),
            .serr(src_serr[s])
         );
      end
   endgenerate

   assign resp_abort = |src_abort;
   assign resp_zero  = |src_zero;
   assign resp_serr  = |src_serr;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
   parameter int NUM_HP = 4
)(
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [2:0]        reg_addr,
   input logic [31:0]       reg_wdata,
   input logic [NUM_HP-1:0] hp_irq,
   input logic              irq_out,
   input logic              resp_abort,
   input logic              resp_serr,
   input logic              sys_err_en,
   input logic [31:0]       ev_q,
   input logic [31:0]       mask_q
);
   // R7
   master_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_q[31] |=> !irq_out);

   // R4
   hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hp_irq != '0) |=> ((ev_q[NUM_HP-1:0] & $past(hp_irq)) == $past(hp_irq)));

   // R4
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_q[0] && !(reg_wr && reg_addr == 3'd1 && reg_wdata[0])) |=> ev_q[0]);

   // R9
   masked_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q[29] && mask_q[30]) |-> (!resp_abort && !resp_serr));

   // R10
   serr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_serr |-> sys_err_en);
endmodule

bind irq_event_ctrl irqc_chk #(.NUM_HP(NUM_HP)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .hp_irq(hp_irq), .irq_out(irq_out),
   .resp_abort(resp_abort), .resp_serr(resp_serr), .sys_err_en(sys_err_en),
   .ev_q(ev_q), .mask_q(mask_q)
);

// File: tb/sim_irq_event_ctrl.sv
`timescale 1ns/1ps
module sim_irq_event_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [3:0]  hp_irq = '0, hp_err = '0;
   logic        gp_irq = 0, hp_posted = 0, gp_err = 0, gp_posted = 0, sys_err_en = 0;
   logic [1:0]  gpio_in = '0;
   logic        irq_out, resp_abort, resp_zero, resp_serr;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #5 clk = ~clk;

   irq_event_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hp_irq(hp_irq),
      .gp_irq(gp_irq), .gpio_in(gpio_in), .hp_err(hp_err),
      .hp_posted(hp_posted), .gp_err(gp_err), .gp_posted(gp_posted),
      .sys_err_en(sys_err_en), .irq_out(irq_out), .resp_abort(resp_abort),
      .resp_zero(resp_zero), .resp_serr(resp_serr)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input string req, input logic [2:0] a, input logic [31:0] exp);
      @(negedge clk);
      reg_addr = a;
      #1;
      chk(req, reg_rdata, exp);
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // {write, addr, data, expected read value}
   localparam int NV = 14;
   localparam logic [67:0] VEC [NV] = '{
      {1'b0, 3'd0, 32'h0,        32'h0000_0000},
      {1'b0, 3'd2, 32'h0,        32'h0000_0000},
      {1'b0, 3'd4, 32'h0,        32'h0000_0000},
      {1'b0, 3'd5, 32'h0,        32'h0000_000F},
      {1'b1, 3'd0, 32'hFFFF_FFFF, 32'h0},
      {1'b0, 3'd1, 32'h0,        32'h3C00_000F},
      {1'b1, 3'd1, 32'h0000_0005, 32'h0},
      {1'b0, 3'd0, 32'h0,        32'h3C00_000A},
      {1'b1, 3'd0, 32'h0,        32'h0},
      {1'b0, 3'd1, 32'h0,        32'h3C00_000A},
      {1'b1, 3'd2, 32'h8000_0002, 32'h0},
      {1'b0, 3'd3, 32'h0,        32'h8000_0002},
      {1'b1, 3'd3, 32'h8000_0000, 32'h0},
      {1'b0, 3'd2, 32'h0,        32'h0000_0002}
   };

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      tick(3);
      #1;
      chk("R1 irq_out after reset", {31'b0, irq_out}, 32'h0);
      rst_n = 1'b1;

      // R1 R2 R3 table walk
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][67]) wr(VEC[i][66:64], VEC[i][63:32]);
         else            rd("R1/R2/R3 vector", VEC[i][66:64], VEC[i][31:0]);
      end
      wr(3'd1, 32'hFFFF_FFFF);
      rd("R2 clear all events", 3'd0, 32'h0);

      // R6 R7: master enable gating (mask holds bit1 only)
      wr(3'd0, 32'h0000_0002);
      tick(2); #1;
      chk("R7 master off keeps irq low", {31'b0, irq_out}, 32'h0);
      wr(3'd2, 32'h8000_0000);
      #1;
      chk("R6 irq not yet registered", {31'b0, irq_out}, 32'h0);
      tick(1); #1;
      chk("R6 irq asserted", {31'b0, irq_out}, 32'h1);
      wr(3'd3, 32'h0000_0002);
      tick(1); #1;
      chk("R6 masked event drops irq", {31'b0, irq_out}, 32'h0);
      wr(3'd2, 32'h0000_0002);
      tick(1); #1;
      chk("R6 irq back", {31'b0, irq_out}, 32'h1);
      wr(3'd3, 32'h8000_0000);
      tick(1); #1;
      chk("R7 master cleared", {31'b0, irq_out}, 32'h0);
      wr(3'd1, 32'hFFFF_FFFF);
      wr(3'd3, 32'hFFFF_FFFF);

      // R4: hardware event against software clear
      @(negedge clk); hp_irq = 4'b0100;
      tick(1);
      wr(3'd1, 32'h0000_0004);
      rd("R4 hw event wins over clear", 3'd0, 32'h0000_0004);
      hp_irq = '0;
      tick(1);
      rd("R4 event sticky after source drops", 3'd0, 32'h0000_0004);
      wr(3'd1, 32'h0000_0004);
      rd("R4 clear takes effect", 3'd0, 32'h0);

      // R11
      @(negedge clk); gp_irq = 1'b1;
      @(negedge clk); gp_irq = 1'b0;
      rd("R11 gp_irq sets bit 26", 3'd0, 32'h0400_0000);
      wr(3'd1, 32'hFFFF_FFFF);

      // R8: pin 0 rising, selected
      wr(3'd5, 32'h0000_010C);
      @(negedge clk); gpio_in[0] = 1'b1;
      tick(5);
      rd("R8 rising edge pin0", 3'd0, 32'h0800_0000);
      wr(3'd1, 32'hFFFF_FFFF);
      @(negedge clk); gpio_in[0] = 1'b0;
      tick(5);
      rd("R8 falling edge ignored for rising type", 3'd0, 32'h0);
      // pin 1 both edges
      wr(3'd5, 32'h0000_020B);
      @(negedge clk); gpio_in[1] = 1'b1;
      tick(5);
      rd("R8 both-edge type rise pin1", 3'd0, 32'h1000_0000);
      wr(3'd1, 32'hFFFF_FFFF);
      @(negedge clk); gpio_in[1] = 1'b0;
      tick(5);
      rd("R8 both-edge type fall pin1", 3'd0, 32'h1000_0000);
      wr(3'd1, 32'hFFFF_FFFF);
      // unselected pin
      wr(3'd5, 32'h0000_0000);
      @(negedge clk); gpio_in = 2'b11;
      tick(5);
      rd("R8 unselected pins ignored", 3'd0, 32'h0);
      @(negedge clk); gpio_in = 2'b00;
      tick(5);
      wr(3'd5, 32'h0000_000F);

      // R5: error report and aggregated bit 30
      @(negedge clk); hp_err = 4'b0010;
      @(negedge clk); hp_err = 4'b0000;
      rd("R5 report bit1", 3'd4, 32'h0000_0002);
      rd("R5 event bit30 from report", 3'd0, 32'h4000_0000);
      @(negedge clk);
      hp_err = 4'b1000; reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 32'h0000_000A;
      @(negedge clk);
      hp_err = 4'b0000; reg_wr = 1'b0; reg_wdata = '0;
      rd("R5 hw error wins over report clear", 3'd4, 32'h0000_0008);
      wr(3'd4, 32'h0000_000F);
      rd("R5 report cleared", 3'd4, 32'h0);
      rd("R5 bit30 follows report", 3'd0, 32'h0);

      // R10: error mask clear
      @(negedge clk); gp_err = 1'b1; gp_posted = 1'b0; #1;
      chk("R10 gp read error abort", {29'b0, resp_abort, resp_zero, resp_serr}, 32'h4);
      gp_posted = 1'b1; sys_err_en = 1'b0; #1;
      chk("R10 posted error serr disabled", {29'b0, resp_abort, resp_zero, resp_serr}, 32'h0);
      sys_err_en = 1'b1; #1;
      chk("R10 posted error serr enabled", {29'b0, resp_abort, resp_zero, resp_serr}, 32'h1);
      @(negedge clk); gp_err = 1'b0; gp_posted = 1'b0;
      rd("R11 gp_err sets bit 29", 3'd0, 32'h2000_0000);
      wr(3'd1, 32'hFFFF_FFFF);

      // R9: error masks set
      wr(3'd2, 32'h6000_0000);
      @(negedge clk); gp_err = 1'b1; #1;
      chk("R9 masked gp read gives zero data", {29'b0, resp_abort, resp_zero, resp_serr}, 32'h2);
      gp_posted = 1'b1; #1;
      chk("R9 masked gp posted no serr", {29'b0, resp_abort, resp_zero, resp_serr}, 32'h0);
      gp_err = 1'b0; gp_posted = 1'b0; hp_err = 4'b0001; #1;
      chk("R9 masked hp read gives zero data", {29'b0, resp_abort, resp_zero, resp_serr}, 32'h2);
      @(negedge clk); hp_err = '0;
      wr(3'd3, 32'h4000_0000);
      @(negedge clk); hp_err = 4'b0100; hp_posted = 1'b1; #1;
      chk("R10 unmasked hp posted serr", {29'b0, resp_abort, resp_zero, resp_serr}, 32'h1);
      @(negedge clk); hp_err = '0; hp_posted = 1'b0; sys_err_en = 1'b0;

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule